// File: doc/BRIEF.md
# Strobed 4-to-16 Line Decoder

This block captures a small binary code in an input store and turns it into a one-hot select bus of sixteen lines. A strobe input opens the store. While the strobe is high, the select bus tracks the code inputs directly. When the strobe falls, the code in place just before the fall is held, and later changes on the code inputs have no effect until the strobe rises again. An inhibit input forces every select line to its idle level. It acts only on the output stage, so the held code is kept and shows again once inhibit is released.

Two elaboration-time options set the variant. `POLARITY` picks how the lines are driven: 0 means the chosen line is 1 and the rest are 0, and 1 inverts all sixteen lines. `SYNC_CAPTURE` replaces the level-sensitive store with flip-flops that load on the falling strobe edge, for flows that do not accept latches. The path from the store to the pins is combinational, so decoding adds no cycles.

Top module: `strobed_line_decoder`

## Requirements
- R1: The code inputs form an index with `code_i[0]` as weight 1 and `code_i[3]` as weight 8. That index selects `sel_o[index]`, so code 0 drives `sel_o[0]` and code 15 drives `sel_o[15]`.
- R2: With `SYNC_CAPTURE`=0 and `strobe_i`=1, the select bus follows `code_i` with no clock delay.
- R3: With `SYNC_CAPTURE`=0, the code present just before `strobe_i` falls is kept. Changes on `code_i` while `strobe_i` stays 0 do not change `sel_o`.
- R4: While `inhibit_i`=1, every line of `sel_o` sits at its idle level: all 0 when `POLARITY`=0 and all 1 when `POLARITY`=1.
- R5: While `inhibit_i`=0, exactly one line of `sel_o` is at the active level and the other fifteen are idle.
- R6: Inhibit does not change the stored code. After `inhibit_i` returns to 0 with the strobe still low, the code held before the inhibit selects the output again, even if `code_i` changed in between.
- R7: With `POLARITY`=1, `sel_o` is the bitwise complement of the `POLARITY`=0 output for the same inputs, so the chosen line is 0.
- R8: With `SYNC_CAPTURE`=1, the stored code loads only on a falling edge of `strobe_i`. While the strobe is high, `sel_o` does not follow `code_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| strobe_i | input | 1 | Store enable: open while high, holds from the falling edge |
| inhibit_i | input | 1 | Forces all select lines to the idle level |
| code_i | input | CODE_W (4) | Binary code, bit 0 least significant |
| sel_o | output | 2**CODE_W (16) | One-hot select bus, polarity set by POLARITY |

## Verification
Every result is due in the same cycle as its stimulus, because no register lies between the inputs and `sel_o` once the store is open. The one exception is the flip-flop variant, whose output changes at the falling strobe edge itself. The bench drives inputs on the falling bench-clock edge and samples one time unit after the next rising edge. By then each combinational result has settled, and every strobe fall has already taken place. Hold behaviour is checked by changing the code one full cycle after the strobe falls and sampling again in the cycle after that.

// File: rtl/strobed_line_decoder_pkg.sv
package strobed_line_decoder_pkg;

   typedef enum logic {
      POL_ACTIVE_HIGH = 1'b0,
      POL_ACTIVE_LOW  = 1'b1
   } sel_polarity_e;

   typedef enum logic {
      STORE_LEVEL = 1'b0,
      STORE_EDGE  = 1'b1
   } store_kind_e;

   function automatic int unsigned line_count(input int unsigned code_w);
      return 32'd1 << code_w;
   endfunction

endpackage

// File: rtl/sld_code_store.sv
module sld_code_store
   import strobed_line_decoder_pkg::*;
#(
   parameter int unsigned CODE_W       = 4,
   parameter bit          SYNC_CAPTURE = 1'b0
) (
   input  logic              strobe_i,
   input  logic [CODE_W-1:0] code_i,
   output logic [CODE_W-1:0] held_o
);

   localparam store_kind_e KIND = SYNC_CAPTURE ? STORE_EDGE : STORE_LEVEL;

   logic [CODE_W-1:0] store_q;

   generate
      if (KIND == STORE_LEVEL) begin : g_level
         always_latch begin
            if (strobe_i) begin
               store_q = code_i;
            end
         end
      end else begin : g_edge
         always_ff @(negedge strobe_i) begin
            store_q <= code_i;
         end
      end
   endgenerate

   assign held_o = store_q;

endmodule

// File: rtl/sld_onehot_array.sv
module sld_onehot_array #(
   parameter int unsigned CODE_W = 4,
   localparam int unsigned LINES = 1 << CODE_W
) (
   input  logic [CODE_W-1:0] code_i,
   output logic [LINES-1:0]  hot_o
);

   generate
      for (genvar ln = 0; ln < LINES; ln++) begin : g_line
         localparam logic [CODE_W-1:0] MATCH = CODE_W'(ln);
         assign hot_o[ln] = (code_i == MATCH);
      end
   endgenerate

endmodule

// File: rtl/sld_drive_stage.sv
module sld_drive_stage
   import strobed_line_decoder_pkg::*;
#(
   parameter int unsigned LINES    = 16,
   parameter bit          POLARITY = 1'b0
) (
   input  logic             inhibit_i,
   input  logic [LINES-1:0] hot_i,
   output logic [LINES-1:0] sel_o
);

   localparam sel_polarity_e POL  = POLARITY ? POL_ACTIVE_LOW : POL_ACTIVE_HIGH;
   localparam logic [LINES-1:0] FLIP = {LINES{POL == POL_ACTIVE_LOW}};

   logic [LINES-1:0] gated;

   always_comb begin
      gated = inhibit_i ? '0 : hot_i;
   end

   assign sel_o = gated ^ FLIP;

endmodule

// File: rtl/strobed_line_decoder.sv
module strobed_line_decoder
   import strobed_line_decoder_pkg::*;
#(
   parameter int unsigned CODE_W       = 4,
   parameter bit          POLARITY     = 1'b0,
   parameter bit          SYNC_CAPTURE = 1'b0,
   localparam int unsigned LINES       = 1 << CODE_W
) (
   input  logic              strobe_i,
   input  logic              inhibit_i,
   input  logic [CODE_W-1:0] code_i,
   output logic [LINES-1:0]  sel_o
);

   generate
      if (CODE_W < 1 || CODE_W > 8) begin : g_bad_width
         $error("strobed_line_decoder: CODE_W must be in 1..8");
      end
      if (line_count(CODE_W) != LINES) begin : g_bad_lines
         $error("strobed_line_decoder: line count mismatch");
      end
   endgenerate

   logic [CODE_W-1:0] held_code;
   logic [LINES-1:0]  hot;

   sld_code_store #(
      .CODE_W       (CODE_W),
      .SYNC_CAPTURE (SYNC_CAPTURE)
   ) store_i (
      .strobe_i (strobe_i),
      .code_i   (code_i),
      .held_o   (held_code)
   );

   sld_onehot_array #(
      .CODE_W (CODE_W)
   ) array_i (
      .code_i (held_code),
      .hot_o  (hot)
   );

   sld_drive_stage #(
      .LINES    (LINES),
      .POLARITY (POLARITY)
   ) drive_i (
      .inhibit_i (inhibit_i),
      .hot_i     (hot),
      .sel_o     (sel_o)
   );

endmodule

// File: rtl/strobed_line_decoder_chk.sv
module strobed_line_decoder_chk #(
   parameter int unsigned CODE_W       = 4,
   parameter bit          POLARITY     = 1'b0,
   parameter bit          SYNC_CAPTURE = 1'b0,
   localparam int unsigned LINES       = 1 << CODE_W
) (
   input logic              strobe_i,
   input logic              inhibit_i,
   input logic [CODE_W-1:0] code_i,
   input logic [LINES-1:0]  sel_o,
   input logic [CODE_W-1:0] held_code
);

   localparam logic [LINES-1:0] IDLE = {LINES{POLARITY}};

   AST_IDLE_WHEN_INHIBITED: assert property (@(negedge inhibit_i)
      sel_o == IDLE);  // R4

   AST_SINGLE_ACTIVE: assert property (@(posedge inhibit_i)
      !$isunknown(held_code) |-> $countones(sel_o ^ IDLE) == 1);  // R5

   AST_HELD_CODE_SHOWN: assert property (@(posedge strobe_i)
      (!inhibit_i && !$isunknown(held_code)) |->
         sel_o == ((LINES'(1) << held_code) ^ IDLE));  // R1

   generate
      if (!SYNC_CAPTURE) begin : g_level_chk
         AST_TRACKS_WHILE_OPEN: assert property (@(negedge strobe_i)
            (!inhibit_i && !$isunknown(code_i)) |->
               sel_o == ((LINES'(1) << code_i) ^ IDLE));  // R2
      end
   endgenerate

endmodule

bind strobed_line_decoder strobed_line_decoder_chk #(
   .CODE_W       (CODE_W),
   .POLARITY     (POLARITY),
   .SYNC_CAPTURE (SYNC_CAPTURE)
) chk_i (
   .strobe_i  (strobe_i),
   .inhibit_i (inhibit_i),
   .code_i    (code_i),
   .sel_o     (sel_o),
   .held_code (held_code)
);

// File: tb/strobed_line_decoder_tb_top.sv
module strobed_line_decoder_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG_CYCLES = 20000;

   logic        clk = 1'b0;
   logic        strobe = 1'b1;
   logic        inhibit = 1'b0;
   logic [3:0]  code = 4'd0;
   logic [15:0] sel_hi;
   logic [15:0] sel_lo;
   logic [15:0] sel_sy;

   int n_checks = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   strobed_line_decoder #(.POLARITY(1'b0), .SYNC_CAPTURE(1'b0)) dut_i (
      .strobe_i(strobe), .inhibit_i(inhibit), .code_i(code), .sel_o(sel_hi));

   strobed_line_decoder #(.POLARITY(1'b1), .SYNC_CAPTURE(1'b0)) dut_lo_i (
      .strobe_i(strobe), .inhibit_i(inhibit), .code_i(code), .sel_o(sel_lo));

   strobed_line_decoder #(.POLARITY(1'b0), .SYNC_CAPTURE(1'b1)) dut_sync_i (
      .strobe_i(strobe), .inhibit_i(inhibit), .code_i(code), .sel_o(sel_sy));

   function automatic logic [15:0] onehot(input int idx);
      return 16'(1) << idx;
   endfunction

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic drive(input logic stb, input logic inh, input logic [3:0] c);
      @(negedge clk);
      strobe  = stb;
      inhibit = inh;
      code    = c;
      @(posedge clk);
      #1;
   endtask

   task automatic t_reset_state();
      @(posedge clk);
      #1;
      check("R1 start code 0", sel_hi, 16'h0001);
      check("R7 start code 0 low", sel_lo, 16'hFFFE);
   endtask

   task automatic t_walk();
      for (int c = 0; c < 16; c++) begin
         drive(1'b1, 1'b0, 4'(c));
         check("R1 R2 walk", sel_hi, onehot(c));
         check("R7 walk low", sel_lo, ~onehot(c));
         check("R5 single line", 16'($countones(sel_hi)), 16'd1);
      end
   endtask

   task automatic t_hold();
      drive(1'b1, 1'b0, 4'd5);
      drive(1'b0, 1'b0, 4'd5);
      check("R8 sync captures on fall", sel_sy, onehot(5));
      drive(1'b0, 1'b0, 4'd10);
      check("R3 hold after fall", sel_hi, onehot(5));
      drive(1'b0, 1'b0, 4'd15);
      check("R3 hold second change", sel_hi, onehot(5));
      check("R8 sync holds", sel_sy, onehot(5));
   endtask

   task automatic t_sync_closed_while_high();
      drive(1'b1, 1'b0, 4'd9);
      check("R2 level follows", sel_hi, onehot(9));
      check("R8 sync not transparent", sel_sy, onehot(5));
      drive(1'b0, 1'b0, 4'd9);
      check("R8 sync loads on fall", sel_sy, onehot(9));
   endtask

   task automatic t_inhibit_held();
      drive(1'b0, 1'b1, 4'd9);
      check("R4 inhibit high variant", sel_hi, 16'h0000);
      check("R4 inhibit low variant", sel_lo, 16'hFFFF);
      check("R4 inhibit sync variant", sel_sy, 16'h0000);
      drive(1'b0, 1'b1, 4'd3);
      check("R4 inhibit with new code", sel_hi, 16'h0000);
      drive(1'b0, 1'b0, 4'd3);
      check("R6 code back after inhibit", sel_hi, onehot(9));
      check("R6 R7 code back low", sel_lo, ~onehot(9));
      check("R6 sync code back", sel_sy, onehot(9));
   endtask

   task automatic t_inhibit_open();
      drive(1'b1, 1'b1, 4'd12);
      check("R4 inhibit while open", sel_hi, 16'h0000);
      check("R4 inhibit while open low", sel_lo, 16'hFFFF);
      drive(1'b1, 1'b0, 4'd12);
      check("R1 release open", sel_hi, onehot(12));
      drive(1'b1, 1'b0, 4'd15);
      check("R1 top code", sel_hi, 16'h8000);
      check("R7 top code low", sel_lo, 16'h7FFF);
      drive(1'b0, 1'b0, 4'd0);
      check("R3 hold top code", sel_hi, 16'h8000);
   endtask

   initial begin
      t_reset_state();
      t_walk();
      t_hold();
      t_sync_closed_while_high();
      t_inhibit_held();
      t_inhibit_open();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (WATCHDOG_CYCLES) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule